// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers a bank of level-sensitive peripheral interrupt lines and hands them to a primary interrupt controller over a vector of request outputs, one bit per primary input. Software keeps a per-line enable mask. It sets mask bits through one write-one register and clears them through another, so read-modify-write sequences are never needed. A masked pending view is available for reading. Every enabled pending line that is not being forwarded directly is ORed into one combined request. That request occupies a fixed slot of the output vector, slot 31 by default.

A second per-line register selects lines that skip the cascade. Each selected line drives the same-numbered bit of the output vector straight from its raw input, whatever its enable bit says. A line selected this way no longer contributes to the combined request. The combined request owns its own slot, so the selection bit for that slot is hardwired to zero.

Register access uses a simple single-cycle bus with a word address. Read data appears one clock after the request.

Top module: `sic_top`

## Requirements
- R1: After synchronous reset the enable mask and the pass-through selection are all zero, the request vector is zero and the read data register is zero.
- R2: A write to word address 2 sets every enable bit whose write-data bit is one and leaves the others unchanged. A read of address 2 returns the enable mask.
- R3: A write to word address 3 clears every enable bit whose write-data bit is one and leaves the others unchanged. A read of address 3 also returns the enable mask.
- R4: A read of word address 0 returns the raw lines ANDed with the enable mask. These bits follow the inputs with no latching, so a line that drops reads as not pending.
- R5: Request bit 31 (the cascade slot) is the OR over all lines of raw AND enable AND NOT pass-through.
- R6: Every other request bit i equals raw line i AND pass-through bit i, with no dependence on the enable mask.
- R7: Word address 4 is the read/write pass-through selection. Its bit 31 is always zero, so writing 0xFFD00000 reads back 0x7FD00000, and line 31 always takes the cascade path.
- R8: Read data is registered one cycle after a read request and holds between reads. Address 1 returns the raw lines. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R9: A line selected for pass-through never raises the cascade request, even while enabled and pending. Clearing its selection returns it to the cascade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| src_lines | input | 32 | Level-sensitive peripheral interrupt lines |
| pri_req | output | 32 | Request vector to the primary controller inputs |

## Verification
On every cycle, the assertions check the following: how the cascade slot is built from the stored mask and selection, that direct slots are independent of the enable mask, that the cascade-slot selection bit stays zero, and the write-one set and clear effects and the immunity of state to unmapped writes. Only the bench scenarios show the rest. These are the register values read back over the bus with their one-cycle latency, the non-latching status when a line drops, the 0xFFD00000 readback, and a routed line moving back into the cascade once its selection is cleared.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND  = 3'd0,
        REG_RAW   = 3'd1,
        REG_ENSET = 3'd2,
        REG_ENCLR = 3'd3,
        REG_ROUTE = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N    = 32,
    parameter int CASC = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic [N-1:0]      raw_in,
    input  logic [N-1:0]      pend_in,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      enable,
    output logic [N-1:0]      route
);
    localparam logic [N-1:0] ONE_HOT_CASC = {{(N-1){1'b0}}, 1'b1} << CASC;
    localparam logic [N-1:0] ROUTE_WMASK  = ~ONE_HOT_CASC;

    typedef struct packed {
        logic [N-1:0] enable;
        logic [N-1:0] route;
        logic [N-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [N-1:0] rd_mux;

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_PEND:  rd_mux = pend_in;
            REG_RAW:   rd_mux = raw_in;
            REG_ENSET: rd_mux = st_q.enable;
            REG_ENCLR: rd_mux = st_q.enable;
            REG_ROUTE: rd_mux = st_q.route;
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bus_valid && bus_write) begin
            case (reg_sel_e'(bus_addr))
                REG_ENSET: st_d.enable = st_q.enable | bus_wdata;
                REG_ENCLR: st_d.enable = st_q.enable & ~bus_wdata;
                REG_ROUTE: st_d.route  = bus_wdata & ROUTE_WMASK;
                default:   st_d = st_q;
            endcase
        end
        if (bus_valid && !bus_write) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign enable = st_q.enable;
    assign route  = st_q.route;
endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int N    = 32,
    parameter int CASC = 31
) (
    input  logic [N-1:0] raw_in,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] route,
    output logic [N-1:0] pend,
    output logic [N-1:0] pri_out
);
    logic casc_req;

    assign pend     = raw_in & enable;
    assign casc_req = |(pend & ~route);

    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == CASC) begin : g_casc
            assign pri_out[i] = casc_req;
        end else begin : g_direct
            assign pri_out[i] = raw_in[i] & route[i];
        end
    end
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int N    = 32,
    parameter int CASC = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      src_lines,
    output logic [N-1:0]      pri_req
);
    logic [N-1:0] en_w;
    logic [N-1:0] rt_w;
    logic [N-1:0] pend_w;

    sic_regs #(.N(N), .CASC(CASC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_in    (src_lines),
        .pend_in   (pend_w),
        .rdata     (bus_rdata),
        .enable    (en_w),
        .route     (rt_w)
    );

    sic_route #(.N(N), .CASC(CASC)) u_route (
        .raw_in  (src_lines),
        .enable  (en_w),
        .route   (rt_w),
        .pend    (pend_w),
        .pri_out (pri_req)
    );
endmodule

// File: rtl/sic_checker.sv
module sic_checker
    import sic_pkg::*;
#(
    parameter int N    = 32,
    parameter int CASC = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      src_lines,
    input logic [N-1:0]      pri_req,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      rt_q
);
    localparam logic [N-1:0] SLOT = {{(N-1){1'b0}}, 1'b1} << CASC;

    // R5
    casc_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pri_req[CASC] == (|(src_lines & en_q & ~rt_q)));

    // R6
    direct_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ((pri_req & ~SLOT) == (src_lines & rt_q & ~SLOT)));

    // R7
    casc_route_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rt_q & SLOT) == '0);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == 3'd2)
        |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == 3'd3)
        |=> ((en_q & $past(bus_wdata)) == '0));

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr > 3'd4)
        |=> ($stable(en_q) && $stable(rt_q)));
endmodule

bind sic_top sic_checker #(.N(N), .CASC(CASC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_lines (src_lines),
    .pri_req   (pri_req),
    .en_q      (en_w),
    .rt_q      (rt_w)
);

// File: tb/sic_top_bench.sv
module sic_top_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] val;
        string       rid;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_lines = '0;
    logic [31:0] pri_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    item_t exp_q[$];

    logic [31:0] en_m = '0;
    logic [31:0] rt_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_top u_sic_top (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lines (src_lines),
        .pri_req   (pri_req)
    );

    task automatic chk(string rid, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rid, act, exp);
        end
    endtask

    function automatic logic [31:0] model_req(logic [31:0] s);
        logic [31:0] r;
        r = s & rt_m & 32'h7FFF_FFFF;
        r[31] = |(s & en_m & ~rt_m);
        return r;
    endfunction

    task automatic check_out(string rid);
        #1;
        chk(rid, pri_req, model_req(src_lines));
    endtask

    task automatic set_src(logic [31:0] v);
        @(negedge clk);
        src_lines = v;
    endtask

    task automatic bus_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        case (a)
            3'd2: en_m = en_m | d;
            3'd3: en_m = en_m & ~d;
            3'd4: rt_m = d & 32'h7FFF_FFFF;
            default: ;
        endcase
    endtask

    task automatic bus_rd(logic [2:0] a, logic [31:0] exp, string rid);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        it.val = exp; it.rid = rid;
        exp_q.push_back(it);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_valid && !bus_write && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.rid, bus_rdata, it.val);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        chk("R1 req", pri_req, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        bus_rd(3'd2, 32'h0, "R1 enable");
        bus_rd(3'd4, 32'h0, "R1 route");

        set_src(32'h0000_00FF);
        check_out("R5 nothing enabled");

        bus_wr(3'd2, 32'h0000_0005);
        check_out("R5 cascade raised");
        bus_rd(3'd2, 32'h0000_0005, "R2 set");
        bus_rd(3'd0, 32'h0000_0005, "R4 pend");

        bus_wr(3'd2, 32'h0000_0100);
        bus_rd(3'd3, 32'h0000_0105, "R2 zeros keep");

        bus_wr(3'd3, 32'h0000_0001);
        bus_rd(3'd2, 32'h0000_0104, "R3 clear");
        bus_rd(3'd0, 32'h0000_0004, "R4 masked");

        set_src(32'h0);
        check_out("R4 lines dropped");
        bus_rd(3'd0, 32'h0, "R4 no latch");

        bus_wr(3'd4, 32'hFFD0_0000);
        bus_rd(3'd4, 32'h7FD0_0000, "R7 route readback");

        set_src(32'h0040_0000);
        check_out("R6 direct without enable");
        chk("R6 direct value", pri_req, 32'h0040_0000);

        bus_wr(3'd2, 32'h0040_0000);
        check_out("R9 routed enabled line");
        chk("R9 no cascade", pri_req, 32'h0040_0000);
        bus_rd(3'd0, 32'h0040_0000, "R4 routed still pending");

        bus_wr(3'd2, 32'h8000_0000);
        set_src(32'h8000_0000);
        check_out("R7 line31 cascades");
        chk("R7 line31 value", pri_req, 32'h8000_0000);

        set_src(32'h0010_0000);
        check_out("R6 line20 direct");
        bus_rd(3'd1, 32'h0010_0000, "R8 raw read");
        bus_rd(3'd7, 32'h0, "R8 unmapped read");

        bus_wr(3'd6, 32'hFFFF_FFFF);
        bus_rd(3'd2, 32'h8040_0104, "R8 unmapped write enable");
        bus_rd(3'd4, 32'h7FD0_0000, "R8 unmapped write route");
        #1;
        chk("R8 rdata hold", bus_rdata, 32'h7FD0_0000);

        bus_wr(3'd4, 32'h0);
        set_src(32'h0040_0000);
        check_out("R9 back to cascade");
        chk("R9 cascade value", pri_req, 32'h8000_0000);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        finish_run();
    end
endmodule